// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block is an execution unit that sits on the memory side, in front of a small store of 64-bit doublewords held in an internal register array. A single requester hands it one operation at a time over a valid/ready request channel and takes the result from a valid/ready response channel. The unit covers the following operations:

- loads and stores of 8, 16, 32 and 64 bits, with zero-extended and sign-extended forms of the byte and halfword loads;
- a store that writes only the bytes selected by a mask;
- a byte test-and-set;
- a 32-bit exchange;
- 32-bit and 64-bit compare-and-swap;
- an indivisible read of two neighbouring doublewords.

Every request follows the same fixed path through a four-state machine. IDLE accepts a request, and its transition goes to READ. READ latches the addressed doubleword and its 16-byte partner, and its transition goes to WRITE. WRITE drives at most one write pulse into the array and forms the response, and its transition goes to RESP. RESP presents the response until the requester takes it, and its transition goes back to IDLE. While a request is in flight the request channel stays closed, so no other access can reach the array between the read and the write of a read-modify-write.

The byte address is split into a doubleword index and a 3-bit offset. For sub-word accesses the lanes inside a doubleword are big-endian: offset 0 is bits [63:56] and offset 7 is bits [7:0]. The masked store does not use that ordering. It numbers its mask bits the way the data bits are numbered.

Top module: `amo_unit`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, and every doubleword of the array reads as zero.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 until the response handshake completes. rsp_valid rises exactly three clock edges after acceptance. While rsp_ready is 0, rsp_valid, rsp_data0, rsp_data1 and rsp_err hold steady.
- R3: Op 9 stores a doubleword and op 5 loads one. All stores (ops 6 to 10) answer with rsp_data0 = 0. For every op except 15, rsp_data1 is 0.
- R4: With big-endian lanes, the byte at offset k is bits [63-8k -: 8], halfword h is bits [63-16h -: 16] and word w is bits [63-32w -: 32]. Ops 6, 7 and 8 store the low 8, 16 and 32 bits of req_wdata into that lane. Ops 0, 2 and 4 load it zero-extended. Ops 1 and 3 load a byte or halfword sign-extended.
- R5: Op 10 writes bits [8N+7:8N] of req_wdata into that bit range of the doubleword for each set bit N of req_mask. Every other byte keeps its old value. A zero mask leaves the doubleword unchanged.
- R6: Op 11 returns the addressed byte's old value, zero-extended, and sets that byte to 0xFF in the same operation.
- R7: Op 12 writes req_wdata[31:0] into the addressed word and returns that word's old value, zero-extended.
- R8: Op 14 compares req_cmp with the addressed doubleword. It writes req_wdata only if they are equal, and returns the old doubleword either way. When the compare fails, the array gets no write pulse.
- R9: Op 13 does the same on a 32-bit word, using req_cmp[31:0] and req_wdata[31:0], and returns the old word zero-extended.
- R10: Op 15 returns the doubleword at the address in rsp_data0 and the doubleword at address+8 in rsp_data1, both taken in the same read cycle.
- R11: A request is misaligned when its address is not a multiple of its size. Sizes are 2 for ops 2, 3 and 7; 4 for ops 4, 8, 12 and 13; 8 for ops 5, 9, 10 and 14; and 16 for op 15. A misaligned request responds with rsp_err = 1 and both data outputs zero, and it leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can accept a request (IDLE) |
| req_op | input | 4 | Operation code (see requirements) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store / swap / new value |
| req_cmp | input | 64 | Compare value for compare-and-swap |
| req_mask | input | 8 | Byte mask for the masked store |
| rsp_valid | output | 1 | Response present (RESP) |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data0 | output | 64 | Load result / old value / first twin doubleword |
| rsp_data1 | output | 64 | Second twin doubleword, else zero |
| rsp_err | output | 1 | Misaligned request |

## Verification
Every result is due three rising edges after the acceptance edge. The old value is latched in READ, the array is written at the end of WRITE, and the response register becomes visible in RESP. The bench drives inputs and samples outputs on falling edges. For each request it counts falling edges from acceptance until rsp_valid, and it flags any count other than three before it reads the data. The effect of a write is confirmed by a later load through the same channel. Under back-pressure, the bench watches the held response and the closed request channel for several extra cycles before it completes the handshake.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [3:0] {
        OP_LDUB   = 4'd0,
        OP_LDSB   = 4'd1,
        OP_LDUH   = 4'd2,
        OP_LDSH   = 4'd3,
        OP_LDW    = 4'd4,
        OP_LDX    = 4'd5,
        OP_STB    = 4'd6,
        OP_STH    = 4'd7,
        OP_STW    = 4'd8,
        OP_STX    = 4'd9,
        OP_STPART = 4'd10,
        OP_TSTSET = 4'd11,
        OP_XCHG   = 4'd12,
        OP_CAS32  = 4'd13,
        OP_CAS64  = 4'd14,
        OP_LDTWIN = 4'd15
    } amo_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_RESP  = 2'd3
    } amo_state_e;

    localparam int DW_BITS  = 64;
    localparam int LANES    = DW_BITS / 8;

endpackage

// File: rtl/amo_align.sv
module amo_align
    import amo_pkg::*;
(
    input  amo_op_e    op,
    input  logic [3:0] addr_lo,
    output logic       misaligned
);

    always_comb begin
        unique case (op)
            OP_LDUB, OP_LDSB, OP_STB, OP_TSTSET:
                misaligned = 1'b0;
            OP_LDUH, OP_LDSH, OP_STH:
                misaligned = addr_lo[0];
            OP_LDW, OP_STW, OP_XCHG, OP_CAS32:
                misaligned = |addr_lo[1:0];
            OP_LDX, OP_STX, OP_STPART, OP_CAS64:
                misaligned = |addr_lo[2:0];
            OP_LDTWIN:
                misaligned = |addr_lo[3:0];
            default:
                misaligned = 1'b1;
        endcase
    end

endmodule

// File: rtl/amo_lanes.sv
module amo_lanes
    import amo_pkg::*;
(
    input  amo_op_e              op,
    input  logic [2:0]           offset,
    input  logic [DW_BITS-1:0]   old_dw,
    input  logic [DW_BITS-1:0]   wdata,
    input  logic [DW_BITS-1:0]   cmp,
    input  logic [LANES-1:0]     mask,
    output logic [DW_BITS-1:0]   new_dw,
    output logic                 wr_en,
    output logic [DW_BITS-1:0]   result
);

    logic [5:0]         b_sh, h_sh, w_sh;
    logic [DW_BITS-1:0] b_msk, h_msk, w_msk, m_exp;
    logic [7:0]         b_val;
    logic [15:0]        h_val;
    logic [31:0]        w_val;
    logic [DW_BITS-1:0] b_sh_data, h_sh_data, w_sh_data;

    // big-endian lane positions: lowest offset is the most significant lane
    assign b_sh = {~offset, 3'b000};
    assign h_sh = {~offset[2:1], 4'b0000};
    assign w_sh = {~offset[2], 5'b00000};

    assign b_msk = {56'd0, 8'hFF}        << b_sh;
    assign h_msk = {48'd0, 16'hFFFF}     << h_sh;
    assign w_msk = {32'd0, 32'hFFFFFFFF} << w_sh;

    assign b_val = 8'(old_dw >> b_sh);
    assign h_val = 16'(old_dw >> h_sh);
    assign w_val = 32'(old_dw >> w_sh);

    assign b_sh_data = {56'd0, wdata[7:0]}  << b_sh;
    assign h_sh_data = {48'd0, wdata[15:0]} << h_sh;
    assign w_sh_data = {32'd0, wdata[31:0]} << w_sh;

    // partial-store mask uses little-endian bit numbering
    for (genvar n = 0; n < LANES; n++) begin : g_mexp
        assign m_exp[8*n +: 8] = {8{mask[n]}};
    end

    always_comb begin
        new_dw = old_dw;
        wr_en  = 1'b0;
        result = '0;
        unique case (op)
            OP_LDUB:   result = {56'd0, b_val};
            OP_LDSB:   result = {{56{b_val[7]}}, b_val};
            OP_LDUH:   result = {48'd0, h_val};
            OP_LDSH:   result = {{48{h_val[15]}}, h_val};
            OP_LDW:    result = {32'd0, w_val};
            OP_LDX:    result = old_dw;
            OP_LDTWIN: result = old_dw;
            OP_STB: begin
                new_dw = (old_dw & ~b_msk) | b_sh_data;
                wr_en  = 1'b1;
            end
            OP_STH: begin
                new_dw = (old_dw & ~h_msk) | h_sh_data;
                wr_en  = 1'b1;
            end
            OP_STW: begin
                new_dw = (old_dw & ~w_msk) | w_sh_data;
                wr_en  = 1'b1;
            end
            OP_STX: begin
                new_dw = wdata;
                wr_en  = 1'b1;
            end
            OP_STPART: begin
                new_dw = (old_dw & ~m_exp) | (wdata & m_exp);
                wr_en  = |mask;
            end
            OP_TSTSET: begin
                result = {56'd0, b_val};
                new_dw = old_dw | b_msk;
                wr_en  = 1'b1;
            end
            OP_XCHG: begin
                result = {32'd0, w_val};
                new_dw = (old_dw & ~w_msk) | w_sh_data;
                wr_en  = 1'b1;
            end
            OP_CAS32: begin
                result = {32'd0, w_val};
                new_dw = (old_dw & ~w_msk) | w_sh_data;
                wr_en  = (w_val == cmp[31:0]);
            end
            OP_CAS64: begin
                result = old_dw;
                new_dw = wdata;
                wr_en  = (old_dw == cmp);
            end
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/amo_store.sv
module amo_store
    import amo_pkg::*;
#(
    parameter int IDX_W = 5,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDX_W-1:0]    widx,
    input  logic [DW_BITS-1:0]  wdat,
    input  logic [IDX_W-1:0]    ridx0,
    input  logic [IDX_W-1:0]    ridx1,
    output logic [DW_BITS-1:0]  rdat0,
    output logic [DW_BITS-1:0]  rdat1
);

    logic [DW_BITS-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[i] <= '0;
            else if (we && (widx == IDX_W'(i)))
                cells[i] <= wdat;
        end
    end

    assign rdat0 = cells[ridx0];
    assign rdat1 = cells[ridx1];

endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    input  logic [63:0]       req_cmp,
    input  logic [7:0]        req_mask,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [63:0]       rsp_data0,
    output logic [63:0]       rsp_data1,
    output logic              rsp_err
);

    localparam int IDX_W = ADDR_W - 3;

    amo_state_e state, state_nxt;

    amo_op_e            op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [63:0]        wdata_q, cmp_q;
    logic [7:0]         mask_q;
    logic               err_q;
    logic [63:0]        old0_q, old1_q;
    logic [63:0]        d0_q, d1_q;
    logic               rerr_q;

    logic               accept, take_old, form_rsp, mem_we;
    logic               misaligned;
    logic [IDX_W-1:0]   idx0, idx1;
    logic [63:0]        rd0, rd1;
    logic [63:0]        lane_new, lane_res;
    logic               lane_we;

    amo_align u_align (
        .op         (amo_op_e'(req_op)),
        .addr_lo    (req_addr[3:0]),
        .misaligned (misaligned)
    );

    assign idx0 = addr_q[ADDR_W-1:3];
    assign idx1 = {addr_q[ADDR_W-1:4], 1'b1};

    amo_store #(.IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .widx  (idx0),
        .wdat  (lane_new),
        .ridx0 (idx0),
        .ridx1 (idx1),
        .rdat0 (rd0),
        .rdat1 (rd1)
    );

    amo_lanes u_lanes (
        .op     (op_q),
        .offset (addr_q[2:0]),
        .old_dw (old0_q),
        .wdata  (wdata_q),
        .cmp    (cmp_q),
        .mask   (mask_q),
        .new_dw (lane_new),
        .wr_en  (lane_we),
        .result (lane_res)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state and control outputs
    always_comb begin
        state_nxt = state;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        accept    = 1'b0;
        take_old  = 1'b0;
        form_rsp  = 1'b0;
        mem_we    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    accept    = 1'b1;
                    state_nxt = ST_READ;
                end
            end
            ST_READ: begin
                take_old  = 1'b1;
                state_nxt = ST_WRITE;
            end
            ST_WRITE: begin
                form_rsp  = 1'b1;
                mem_we    = lane_we && !err_q;
                state_nxt = ST_RESP;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                if (rsp_ready) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // request capture, read latch, response formation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_LDUB;
            addr_q  <= '0;
            wdata_q <= '0;
            cmp_q   <= '0;
            mask_q  <= '0;
            err_q   <= 1'b0;
            old0_q  <= '0;
            old1_q  <= '0;
            d0_q    <= '0;
            d1_q    <= '0;
            rerr_q  <= 1'b0;
        end else begin
            if (accept) begin
                op_q    <= amo_op_e'(req_op);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                cmp_q   <= req_cmp;
                mask_q  <= req_mask;
                err_q   <= misaligned;
            end
            if (take_old) begin
                old0_q <= rd0;
                old1_q <= rd1;
            end
            if (form_rsp) begin
                rerr_q <= err_q;
                d0_q   <= err_q ? '0 : lane_res;
                d1_q   <= (!err_q && op_q == OP_LDTWIN) ? old1_q : '0;
            end
        end
    end

    assign rsp_data0 = d0_q;
    assign rsp_data1 = d1_q;
    assign rsp_err   = rerr_q;

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [63:0] rsp_data0,
    input logic [63:0] rsp_data1,
    input logic        rsp_err,
    input logic        mem_we
);

    // R2: channel closes after acceptance
    a_r2_closed_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: fixed response latency
    a_r2_resp_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##3 rsp_valid);

    // R2: response held under back-pressure
    a_r2_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data0)
                                       && $stable(rsp_data1) && $stable(rsp_err)));

    // R2: no acceptance while a response is pending
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R11: an error response was preceded by no array write
    a_r11_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && rsp_err) |-> !$past(mem_we));

    // R8: every array write belongs to a good response that follows at once
    a_r8_write_then_resp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (rsp_valid && !rsp_err));

endmodule

bind amo_unit amo_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data0 (rsp_data0),
    .rsp_data1 (rsp_data1),
    .rsp_err   (rsp_err),
    .mem_we    (mem_we)
);

// File: tb/amo_unit_test.sv
`timescale 1ns/1ps
module amo_unit_test;
    import amo_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic [7:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] req_cmp = '0;
    logic [7:0]  req_mask = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [63:0] rsp_data0, rsp_data1;
    logic        rsp_err;

    int n_run = 0;
    int n_fail = 0;
    logic [63:0] g_d0, g_d1;
    logic        g_err;

    always #4 clk = ~clk;

    amo_unit #(.ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data0(rsp_data0), .rsp_data1(rsp_data1), .rsp_err(rsp_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one request; holds the response for 'hold' extra cycles when nonzero
    task automatic issue(input amo_op_e op, input logic [7:0] addr, input logic [63:0] wd,
                         input logic [63:0] cm, input logic [7:0] mk, input int hold);
        int lat;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr;
        req_wdata = wd; req_cmp = cm; req_mask = mk;
        rsp_ready = (hold == 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check("R2 latency", 64'(lat), 64'd3);
        g_d0 = rsp_data0; g_d1 = rsp_data1; g_err = rsp_err;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check("R2 held valid", {63'd0, rsp_valid}, 64'd1);
            check("R2 ready low", {63'd0, req_ready}, 64'd0);
            check("R2 data stable", rsp_data0, g_d0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R2 ready back", {63'd0, req_ready}, 64'd1);
    endtask

    function automatic logic [63:0] z(); return 64'd0; endfunction

    task automatic t_reset();
        check("R1 ready", {63'd0, req_ready}, 64'd1);
        check("R1 valid", {63'd0, rsp_valid}, 64'd0);
        issue(OP_LDX, 8'h40, z(), z(), 8'h0, 0);
        check("R1 zero array", g_d0, 64'd0);
    endtask

    task automatic t_dword();
        issue(OP_STX, 8'h08, 64'h0123456789ABCDEF, z(), 8'h0, 0);
        check("R3 store rsp0", g_d0, 64'd0);
        check("R3 store rsp1", g_d1, 64'd0);
        issue(OP_LDX, 8'h08, z(), z(), 8'h0, 0);
        check("R3 load", g_d0, 64'h0123456789ABCDEF);
    endtask

    task automatic t_lanes();
        issue(OP_STX, 8'h10, z(), z(), 8'h0, 0);
        issue(OP_STB, 8'h13, 64'h00000000000000A5, z(), 8'h0, 0);
        issue(OP_LDX, 8'h10, z(), z(), 8'h0, 0);
        check("R4 byte lane", g_d0, 64'h000000A500000000);
        issue(OP_LDUB, 8'h13, z(), z(), 8'h0, 0);
        check("R4 ldub", g_d0, 64'h00000000000000A5);
        issue(OP_LDSB, 8'h13, z(), z(), 8'h0, 0);
        check("R4 ldsb", g_d0, 64'hFFFFFFFFFFFFFFA5);
        issue(OP_STH, 8'h16, 64'h0000000000008001, z(), 8'h0, 0);
        issue(OP_LDSH, 8'h16, z(), z(), 8'h0, 0);
        check("R4 ldsh", g_d0, 64'hFFFFFFFFFFFF8001);
        issue(OP_LDUH, 8'h16, z(), z(), 8'h0, 0);
        check("R4 lduh", g_d0, 64'h0000000000008001);
        issue(OP_STW, 8'h10, 64'h00000000DEADBEEF, z(), 8'h0, 0);
        issue(OP_LDX, 8'h10, z(), z(), 8'h0, 0);
        check("R4 word lane", g_d0, 64'hDEADBEEF00008001);
        issue(OP_LDW, 8'h14, z(), z(), 8'h0, 0);
        check("R4 ldw low", g_d0, 64'h0000000000008001);
    endtask

    task automatic t_partial();
        issue(OP_STX, 8'h18, 64'h1111111111111111, z(), 8'h0, 0);
        issue(OP_STPART, 8'h18, 64'hAABBCCDDEEFF0022, z(), 8'h81, 0);
        check("R5 part rsp", g_d0, 64'd0);
        issue(OP_LDX, 8'h18, z(), z(), 8'h0, 0);
        check("R5 mask 81", g_d0, 64'hAA11111111111122);
        issue(OP_STPART, 8'h18, 64'h0, z(), 8'h00, 0);
        issue(OP_LDX, 8'h18, z(), z(), 8'h0, 0);
        check("R5 mask zero", g_d0, 64'hAA11111111111122);
    endtask

    task automatic t_tstset();
        issue(OP_STX, 8'h20, 64'h0102030405060708, z(), 8'h0, 0);
        issue(OP_TSTSET, 8'h22, z(), z(), 8'h0, 0);
        check("R6 old byte", g_d0, 64'h03);
        issue(OP_LDX, 8'h20, z(), z(), 8'h0, 0);
        check("R6 set ff", g_d0, 64'h0102FF0405060708);
        issue(OP_TSTSET, 8'h22, z(), z(), 8'h0, 0);
        check("R6 again", g_d0, 64'hFF);
    endtask

    task automatic t_xchg();
        issue(OP_STX, 8'h28, 64'h1122334455667788, z(), 8'h0, 0);
        issue(OP_XCHG, 8'h2C, 64'h00000000CAFEF00D, z(), 8'h0, 0);
        check("R7 old word", g_d0, 64'h55667788);
        issue(OP_LDX, 8'h28, z(), z(), 8'h0, 0);
        check("R7 new word", g_d0, 64'h11223344CAFEF00D);
    endtask

    task automatic t_cas64();
        issue(OP_STX, 8'h30, 64'd5, z(), 8'h0, 0);
        issue(OP_CAS64, 8'h30, 64'd9, 64'd5, 8'h0, 0);
        check("R8 hit old", g_d0, 64'd5);
        issue(OP_CAS64, 8'h30, 64'd7, 64'd5, 8'h0, 0);
        check("R8 miss old", g_d0, 64'd9);
        issue(OP_LDX, 8'h30, z(), z(), 8'h0, 0);
        check("R8 miss kept", g_d0, 64'd9);
    endtask

    task automatic t_cas32();
        issue(OP_STX, 8'h38, 64'hAAAAAAAA00000010, z(), 8'h0, 0);
        issue(OP_CAS32, 8'h3C, 64'h20, 64'hFFFFFFFF00000010, 8'h0, 0);
        check("R9 hit old", g_d0, 64'h10);
        issue(OP_CAS32, 8'h38, 64'h0, 64'h1, 8'h0, 0);
        check("R9 miss old", g_d0, 64'hAAAAAAAA);
        issue(OP_LDX, 8'h38, z(), z(), 8'h0, 0);
        check("R9 result", g_d0, 64'hAAAAAAAA00000020);
    endtask

    task automatic t_twin();
        issue(OP_STX, 8'h40, 64'hA0A0A0A0A0A0A0A0, z(), 8'h0, 0);
        issue(OP_STX, 8'h48, 64'hB1B1B1B1B1B1B1B1, z(), 8'h0, 0);
        issue(OP_LDTWIN, 8'h40, z(), z(), 8'h0, 0);
        check("R10 first", g_d0, 64'hA0A0A0A0A0A0A0A0);
        check("R10 second", g_d1, 64'hB1B1B1B1B1B1B1B1);
    endtask

    task automatic t_misalign();
        issue(OP_LDTWIN, 8'h48, z(), z(), 8'h0, 0);
        check("R11 twin err", {63'd0, g_err}, 64'd1);
        check("R11 twin data", g_d1, 64'd0);
        issue(OP_STX, 8'h41, 64'h1234, z(), 8'h0, 0);
        check("R11 stx err", {63'd0, g_err}, 64'd1);
        issue(OP_XCHG, 8'h42, 64'h1234, z(), 8'h0, 0);
        check("R11 xchg err", {63'd0, g_err}, 64'd1);
        issue(OP_CAS64, 8'h44, 64'h0, 64'hA0A0A0A0A0A0A0A0, 8'h0, 0);
        check("R11 cas err", {63'd0, g_err}, 64'd1);
        issue(OP_LDUH, 8'h43, z(), z(), 8'h0, 0);
        check("R11 lduh err", {63'd0, g_err}, 64'd1);
        check("R11 lduh data", g_d0, 64'd0);
        issue(OP_LDX, 8'h40, z(), z(), 8'h0, 0);
        check("R11 unchanged", g_d0, 64'hA0A0A0A0A0A0A0A0);
        check("R11 good no err", {63'd0, g_err}, 64'd0);
    endtask

    task automatic t_backpressure();
        issue(OP_LDX, 8'h08, z(), z(), 8'h0, 4);
        check("R2 bp data", g_d0, 64'h0123456789ABCDEF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dword();
        t_lanes();
        t_partial();
        t_tstset();
        t_xchg();
        t_cas64();
        t_cas32();
        t_twin();
        t_misalign();
        t_backpressure();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule